// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into one level interrupt output for a processor. Each line first passes through a two-flop synchronizer. The synchronized levels form the line image. On every clock the line image is ORed into a sticky pending register. The output is raised while any pending bit is also enabled in the mask register.

Software drives the block through a plain synchronous port. One strobe writes either the whole mask or an acknowledge pattern, and a combinational read port returns the mask, the pending bits, the line image or one per-line event counter. Each counter records how many times its synchronized line has risen. Because the line image is ORed back in every cycle, a pending bit whose source is still high cannot be cleared. Software must quiet the source before it acknowledges.

Top module: `irq_pic`

## Requirements
- R1: After reset the mask, pending bits, line image and all 32 counters read zero, and `irq_o` is low.
- R2: A line's pending bit is set on the third rising clock edge after the line goes high: two edges pass through the synchronizer and the third loads the pending register. The bit stays set after the line falls, until it is acknowledged.
- R3: A write with `wr_sel_i` = 1 (acknowledge) clears every pending bit whose data bit is 1 and whose line image bit is 0, on that edge. Pending bits written with 0 keep their value.
- R4: A pending bit whose line image bit is 1 stays set through an acknowledge, including an acknowledge on the same edge that first loads it.
- R5: `irq_o` is registered. On each edge it takes the OR of (pending AND mask) as held before that edge, so it lags any register change by one clock.
- R6: A write with `wr_sel_i` = 0 replaces all 32 mask bits with `wr_data_i` on that edge.
- R7: A line's counter adds one for each rising edge of its synchronized level. A line held high counts once, and a falling level leaves the counter unchanged. Counters wrap modulo 2^32.
- R8: Reads are combinational and have no side effects. `rd_sel_i` selects: 0 = mask, 1 = pending, 2 = the counter of line `rd_idx_i`, 3 = line image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 32 | Asynchronous interrupt request levels |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 acknowledge |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read source select |
| rd_idx_i | input | 5 | Counter index for counter reads |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the same edge that first loads a pending bit from a freshly synchronized line. The bench raises the line and waits exactly two edges, so the acknowledge strobe coincides with the third edge. It then checks that the bit survives. A sweep over all 32 lines gives line n exactly n+1 rising edges while also holding it high across several acknowledges. Each counter's final value then shows both the single count per held level and the absence of cross-talk between lines.

// File: rtl/irq_pic_pkg.sv
package irq_pic_pkg;
  typedef enum logic [1:0] {
    RD_MASK = 2'd0,
    RD_PEND = 2'd1,
    RD_CNT  = 2'd2,
    RD_LINE = 2'd3
  } rd_sel_e;

  typedef enum logic {
    WR_MASK = 1'b0,
    WR_ACK  = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_counters.sv
module irq_counters #(
  parameter int N_LINES = 32,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] inc_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [N_LINES-1:0][CNT_W-1:0] cnt_q;

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_cnt
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      cnt_q[g] <= '0;
        else if (inc_i[g]) cnt_q[g] <= cnt_q[g] + 1'b1; // wraps

      p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_i[g] |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1);
      p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inc_i[g] |=> $stable(cnt_q[g]));
    end
  endgenerate

  assign cnt_o = (32'(idx_i) < N_LINES) ? cnt_q[idx_i] : '0;
endmodule

// File: rtl/irq_pic.sv
module irq_pic
  import irq_pic_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int CNT_W       = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [1:0]         rd_sel_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] line_img, line_prev_q, rise;
  logic [N_LINES-1:0] mask_q, pend_q, pend_d, ack_vec;
  logic [CNT_W-1:0]   cnt_rd;
  logic               irq_q;

  irq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_img)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) line_prev_q <= '0;
    else         line_prev_q <= line_img;

  assign rise = line_img & ~line_prev_q;

  irq_counters #(.N_LINES(N_LINES), .CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (rise),
    .idx_i (rd_idx_i),
    .cnt_o (cnt_rd)
  );

  assign ack_vec = (wr_en_i && wr_sel_e'(wr_sel_i) == WR_ACK) ? wr_data_i[N_LINES-1:0] : '0;
  // re-latch from the line image wins over the clear
  assign pend_d  = (pend_q & ~ack_vec) | line_img;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_e'(wr_sel_i) == WR_MASK) mask_q <= wr_data_i[N_LINES-1:0];
      pend_q <= pend_d;
      irq_q  <= |(pend_q & mask_q);
    end

  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_MASK: rd_data_o = DATA_W'(mask_q);
      RD_PEND: rd_data_o = DATA_W'(pend_q);
      RD_CNT:  rd_data_o = DATA_W'(cnt_rd);
      RD_LINE: rd_data_o = DATA_W'(line_img);
      default: rd_data_o = '0;
    endcase
  end

  p_relatch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & $past(line_img)) == $past(line_img));
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(pend_q) & ~pend_q & ~$past(ack_vec)) == '0);
  p_ack_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vec != '0) |=> (pend_q & $past(ack_vec & ~line_img)) == '0);
  p_mask_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> mask_q == $past(wr_data_i[N_LINES-1:0]));
  p_irq_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & mask_q)) |=> irq_o);
  p_irq_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(pend_q & mask_q)) |=> !irq_o);
  p_rise_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> (rise & $past(rise)) == '0);
endmodule

// File: tb/test_irq_pic.sv
module test_irq_pic;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lines = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cycles  = 0;
  int exp_cnt [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pic i_irq_pic (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(lines),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, input logic [4:0] idx, output logic [31:0] d);
    rd_sel = sel; rd_idx = idx; #1; d = rd_data;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input int i);
    lines[i] = 1'b1; tick(3);
    lines[i] = 1'b0; tick(3);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d, d2, pat, ack;
    for (int i = 0; i < 32; i++) exp_cnt[i] = 0;
    tick(3);
    rst_ni = 1'b1;
    tick(1);

    // R1 reset state
    rd(2'd0, 0, d); check("R1 mask", d, 0);
    rd(2'd1, 0, d); check("R1 pending", d, 0);
    rd(2'd3, 0, d); check("R1 line", d, 0);
    for (int i = 0; i < 32; i++) begin
      rd(2'd2, 5'(i), d); check("R1 counter", d, 0);
    end
    check("R1 irq", {31'd0, irq}, 0);

    // R6 mask replace
    wr(1'b0, 32'hA5A5_0F0F);
    rd(2'd0, 0, d); check("R6 mask load", d, 32'hA5A5_0F0F);
    wr(1'b0, 32'h1234_8000);
    rd(2'd0, 0, d); check("R6 mask replace", d, 32'h1234_8000);
    wr(1'b0, 32'h0);

    // per-line sweep
    for (int i = 0; i < 32; i++) begin
      lines[i] = 1'b1;
      tick(2);
      rd(2'd1, 0, d); check("R2 not yet pending", d, 0);
      tick(1);
      rd(2'd1, 0, d); check("R2 pending latency", d, 32'(1) << i);
      rd(2'd3, 0, d); check("R8 line image", d, 32'(1) << i);
      exp_cnt[i]++;
      check("R5 masked off", {31'd0, irq}, 0);
      wr(1'b0, 32'(1) << i);
      check("R5 irq lag", {31'd0, irq}, 0);
      tick(1);
      check("R5 irq raised", {31'd0, irq}, 1);
      wr(1'b1, 32'(1) << i);
      rd(2'd1, 0, d); check("R4 ack while high", d, 32'(1) << i);
      tick(3);
      rd(2'd2, 5'(i), d); check("R7 held counts once", d, 1);
      lines[i] = 1'b0;
      tick(4);
      rd(2'd1, 0, d); check("R2 sticky after fall", d, 32'(1) << i);
      rd(2'd2, 5'(i), d); check("R7 fall no count", d, 1);
      wr(1'b1, 32'(1) << i);
      rd(2'd1, 0, d); check("R3 ack clears", d, 0);
      check("R5 irq lag fall", {31'd0, irq}, 1);
      tick(1);
      check("R5 irq dropped", {31'd0, irq}, 0);
      for (int k = 0; k < i; k++) begin
        pulse(i);
        exp_cnt[i]++;
      end
      wr(1'b1, 32'hFFFF_FFFF);
      wr(1'b0, 32'h0);
    end

    // R7/R8 final counters, read twice
    for (int i = 0; i < 32; i++) begin
      rd(2'd2, 5'(i), d);
      rd(2'd2, 5'(i), d2);
      check("R7 counter total", d, 32'(exp_cnt[i]));
      check("R8 read no side effect", d2, d);
    end

    // R3 partial acknowledge
    pat = 32'hF0F0_3C3C;
    ack = 32'h3030_FF00;
    lines = pat; tick(3);
    lines = '0; tick(4);
    rd(2'd1, 0, d); check("R2 pattern pending", d, pat);
    wr(1'b1, ack);
    rd(2'd1, 0, d); check("R3 partial ack", d, pat & ~ack);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(2'd1, 0, d); check("R3 ack all", d, 0);

    // R4 ack on the edge that first loads the bit
    lines[7] = 1'b1;
    tick(2);
    wr(1'b1, 32'h0000_0080);
    rd(2'd1, 0, d); check("R4 same-edge ack", d, 32'h0000_0080);
    lines[7] = 1'b0;
    tick(4);
    wr(1'b1, 32'h0000_0080);
    rd(2'd1, 0, d); check("R3 ack after fall", d, 0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule